// File: doc/BRIEF.md
# Ten-Bit I2C Mailbox Slave

This block is an I2C slave that answers only to 10-bit addresses. A bus master reaches one entry of a sixteen-byte register file with each addressed transfer. The local host shares that file as a mailbox through a simple synchronous port. The block samples SCL and SDA through synchronizers, pulls SDA low through an open-drain enable, and recognises start, repeated start and stop conditions. It also recognises the special start byte that some masters send to wake slow slaves.

Each transfer moves exactly one data byte. A write stores the byte into the selected entry and raises a ready flag. A read shifts the selected entry out to the master. Aborts are reported in a status byte: a stop in mid-transfer, a repeated start, or a clock watchdog expiry. The host clears the ready flag with a write-one-to-clear strobe.

Top module: `i2c10_mbox_slave`

## Requirements
- R1: After reset the status byte is 00h, the SDA enable is low, and every mailbox entry reads 00h.
- R2: When host_we is high at a clock edge, host_wdata is stored in entry host_addr; host_rdata shows entry host_addr combinationally.
- R3: The first address byte (bit 0 is R/W) is acknowledged only when, with bit 0 forced to zero, it equals cfg_id_hi. On a mismatch the slave gives no ACK and stays idle until the next start.
- R4: The second address byte is acknowledged only when its upper four bits equal cfg_id_lo. Its lower four bits select the mailbox entry.
- R5: An ACK pulls SDA low from the SCL fall that ends the eighth bit until the next SCL fall. The SDA enable only rises while SCL is low.
- R6: With R/W = 0, the data byte is sampled MSB first on SCL rises, stored in the selected entry and acknowledged. Status bit 0 (ready) is set when that ACK clock ends.
- R7: With R/W = 1, the selected entry is driven MSB first, each bit changing after an SCL fall. Status bit 6 is set for such a transfer.
- R8: Status bit 1 (overflow) is set when a write completes while ready is still set and ready_clr is low in that cycle. Ready falls only when ready_clr is pulsed.
- R9: A first byte of 01h is never acknowledged. A start within cfg_start_tmo cycles afterwards begins address decoding and sets no status flag. Otherwise the slave returns to idle, sets no flag, and ignores further bits until a start.
- R10: A stop (SDA rising while SCL is high) during a transfer aborts it and sets status bits 3 and 7. The addressed entry is left unchanged.
- R11: A start seen during a transfer sets status bit 4 and restarts decoding at the first address byte.
- R12: If no SCL edge arrives for cfg_clk_tmo cycles during a transfer, the transfer aborts and status bits 5 and 7 are set.
- R13: A start that begins a transfer from idle clears every status bit except bit 0. Status bit 2 always reads zero.
- R14: When the host and the bus write the same entry in the same cycle, the host data is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| sda_oe_o | output | 1 | High pulls SDA low |
| cfg_id_hi | input | 8 | First address byte match value, bit 0 zero |
| cfg_id_lo | input | 4 | Match value for the upper nibble of the second address byte |
| cfg_clk_tmo | input | 16 | SCL edge watchdog, in clock cycles |
| cfg_start_tmo | input | 16 | Wait for a start after a start byte, in clock cycles |
| host_we | input | 1 | Host write strobe |
| host_addr | input | 4 | Host entry index |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Entry selected by host_addr |
| ready_clr | input | 1 | Clears status bit 0 |
| status_o | output | 8 | Status byte |

## Verification
The hardest case to reach from the ports is a host write that lands in the same cycle as the bus write to the same entry. The bus write happens a fixed number of system clocks after the SCL fall that ends the eighth data bit: two synchronizer stages, then the edge detector. The bench therefore drives that fall on a known clock edge and holds host_we over the cycles that contain the bus write. A wrong priority then leaves the bus byte in the entry. The start-byte path is reached by sending 01h and then either a repeated start or an idle gap longer than cfg_start_tmo.

// File: rtl/i2c10_pkg.sv
package i2c10_pkg;
    localparam int BYTE_W = 8;
    localparam logic [BYTE_W-1:0] WAKE_BYTE = 8'h01;

    typedef enum logic [2:0] {
        E_IDLE, E_RX, E_ACK_LO, E_ACK_HI, E_TX_LO, E_TX_HI, E_WAKE
    } eng_state_e;

    typedef enum logic [1:0] {
        P_HDR, P_SUB, P_DATA
    } phase_e;

    localparam int SB_READY  = 0;
    localparam int SB_OVF    = 1;
    localparam int SB_STOP   = 3;
    localparam int SB_RSTART = 4;
    localparam int SB_TMO    = 5;
    localparam int SB_TX     = 6;
    localparam int SB_ERR    = 7;
endpackage

// File: rtl/i2c10_sync.sv
module i2c10_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    logic [STAGES-1:0] scl_pipe_d, scl_pipe_q, sda_pipe_d, sda_pipe_q;
    logic scl_prev_d, scl_prev_q, sda_prev_d, sda_prev_q;
    logic scl_s;

    assign scl_s = scl_pipe_q[STAGES-1];
    assign sda_s = sda_pipe_q[STAGES-1];

    always_comb begin
        scl_pipe_d = {scl_pipe_q[STAGES-2:0], scl_i};
        sda_pipe_d = {sda_pipe_q[STAGES-2:0], sda_i};
        scl_prev_d = scl_s;
        sda_prev_d = sda_s;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_pipe_q <= '1;
            sda_pipe_q <= '1;
            scl_prev_q <= 1'b1;
            sda_prev_q <= 1'b1;
        end else begin
            scl_pipe_q <= scl_pipe_d;
            sda_pipe_q <= sda_pipe_d;
            scl_prev_q <= scl_prev_d;
            sda_prev_q <= sda_prev_d;
        end
    end

    assign scl_rise  = scl_s & ~scl_prev_q;
    assign scl_fall  = ~scl_s & scl_prev_q;
    assign start_det = scl_s & scl_prev_q & sda_prev_q & ~sda_s;
    assign stop_det  = scl_s & scl_prev_q & ~sda_prev_q & sda_s;
endmodule

// File: rtl/i2c10_mailbox.sv
module i2c10_mailbox
    import i2c10_pkg::*;
#(
    parameter int IDX_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_we,
    input  logic [IDX_W-1:0]  host_addr,
    input  logic [BYTE_W-1:0] host_wdata,
    output logic [BYTE_W-1:0] host_rdata,
    input  logic              bus_we,
    input  logic [IDX_W-1:0]  bus_idx,
    input  logic [BYTE_W-1:0] bus_wdata,
    output logic [BYTE_W-1:0] bus_rdata
);
    localparam int ENTRIES = 1 << IDX_W;

    logic [BYTE_W-1:0] mem_d [ENTRIES];
    logic [BYTE_W-1:0] mem_q [ENTRIES];

    always_comb begin
        for (int i = 0; i < ENTRIES; i++) begin
            mem_d[i] = mem_q[i];
            if (host_we && host_addr == IDX_W'(i))
                mem_d[i] = host_wdata;
            else if (bus_we && bus_idx == IDX_W'(i))
                mem_d[i] = bus_wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < ENTRIES; i++) mem_q[i] <= '0;
        end else begin
            for (int i = 0; i < ENTRIES; i++) mem_q[i] <= mem_d[i];
        end
    end

    assign host_rdata = mem_q[host_addr];
    assign bus_rdata  = mem_q[bus_idx];
endmodule

// File: rtl/i2c10_engine.sv
module i2c10_engine
    import i2c10_pkg::*;
#(
    parameter int TMO_W = 16,
    parameter int IDX_W = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    sda_s,
    input  logic                    scl_rise,
    input  logic                    scl_fall,
    input  logic                    start_det,
    input  logic                    stop_det,
    input  logic [BYTE_W-1:0]       cfg_id_hi,
    input  logic [BYTE_W-IDX_W-1:0] cfg_id_lo,
    input  logic [TMO_W-1:0]        cfg_clk_tmo,
    input  logic [TMO_W-1:0]        cfg_start_tmo,
    input  logic                    ready_clr,
    input  logic [BYTE_W-1:0]       bus_rdata,
    output logic                    bus_we,
    output logic [IDX_W-1:0]        bus_idx,
    output logic [BYTE_W-1:0]       bus_wdata,
    output logic                    sda_oe,
    output logic [BYTE_W-1:0]       status
);
    localparam int CNT_W = $clog2(BYTE_W) + 1;
    localparam int TAG_W = BYTE_W - IDX_W;

    typedef struct packed {
        eng_state_e        st;
        phase_e            ph;
        logic [BYTE_W-1:0] sh;
        logic [CNT_W-1:0]  cnt;
        logic              rw;
        logic [IDX_W-1:0]  idx;
        logic [TMO_W-1:0]  tmo;
        logic [BYTE_W-1:0] stat;
    } eng_t;

    eng_t q, d;
    logic scl_edge, tmo_hit, ready_keep;

    always_comb begin
        d          = q;
        bus_we     = 1'b0;
        scl_edge   = scl_rise | scl_fall;
        ready_keep = q.stat[SB_READY] & ~ready_clr;
        tmo_hit    = (q.st == E_WAKE) ? (q.tmo == '0) : (q.tmo == '0 && !scl_edge);

        if (ready_clr) d.stat[SB_READY] = 1'b0;
        if (q.tmo != '0) d.tmo = q.tmo - 1'b1;
        if (scl_edge && q.st != E_WAKE) d.tmo = cfg_clk_tmo;

        if (start_det) begin
            d.stat           = '0;
            d.stat[SB_READY] = ready_keep;
            if (q.st != E_IDLE && q.st != E_WAKE) d.stat[SB_RSTART] = 1'b1;
            d.st  = E_RX;
            d.ph  = P_HDR;
            d.cnt = '0;
            d.rw  = 1'b0;
            d.tmo = cfg_clk_tmo;
        end else if (stop_det && q.st != E_IDLE) begin
            d.stat[SB_STOP] = 1'b1;
            d.stat[SB_ERR]  = 1'b1;
            d.st            = E_IDLE;
        end else if (q.st != E_IDLE && tmo_hit) begin
            if (q.st != E_WAKE) begin
                d.stat[SB_TMO] = 1'b1;
                d.stat[SB_ERR] = 1'b1;
            end
            d.st = E_IDLE;
        end else begin
            case (q.st)
                E_RX: begin
                    if (scl_rise) begin
                        d.sh  = {q.sh[BYTE_W-2:0], sda_s};
                        d.cnt = q.cnt + 1'b1;
                    end else if (scl_fall && q.cnt == CNT_W'(BYTE_W)) begin
                        d.cnt = '0;
                        case (q.ph)
                            P_HDR: begin
                                if (q.sh == WAKE_BYTE) begin
                                    d.st  = E_WAKE;
                                    d.tmo = cfg_start_tmo;
                                end else if ({q.sh[BYTE_W-1:1], 1'b0} == cfg_id_hi) begin
                                    d.rw           = q.sh[0];
                                    d.stat[SB_TX]  = q.sh[0];
                                    d.st           = E_ACK_LO;
                                end else begin
                                    d.st = E_IDLE;
                                end
                            end
                            P_SUB: begin
                                if (q.sh[BYTE_W-1 -: TAG_W] == cfg_id_lo) begin
                                    d.idx = q.sh[IDX_W-1:0];
                                    d.st  = E_ACK_LO;
                                end else begin
                                    d.st = E_IDLE;
                                end
                            end
                            default: begin
                                bus_we = 1'b1;
                                d.st   = E_ACK_LO;
                            end
                        endcase
                    end
                end
                E_ACK_LO: if (scl_rise) d.st = E_ACK_HI;
                E_ACK_HI: begin
                    if (scl_fall) begin
                        case (q.ph)
                            P_HDR: begin
                                d.ph = P_SUB;
                                d.st = E_RX;
                            end
                            P_SUB: begin
                                d.ph = P_DATA;
                                if (q.rw) begin
                                    d.st  = E_TX_LO;
                                    d.sh  = bus_rdata;
                                    d.cnt = '0;
                                end else begin
                                    d.st = E_RX;
                                end
                            end
                            default: begin
                                if (ready_keep) d.stat[SB_OVF] = 1'b1;
                                d.stat[SB_READY] = 1'b1;
                                d.st             = E_IDLE;
                            end
                        endcase
                    end
                end
                E_TX_LO: if (scl_rise) d.st = E_TX_HI;
                E_TX_HI: begin
                    if (scl_fall) begin
                        d.sh  = {q.sh[BYTE_W-2:0], 1'b0};
                        d.cnt = q.cnt + 1'b1;
                        d.st  = (q.cnt == CNT_W'(BYTE_W - 1)) ? E_IDLE : E_TX_LO;
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign bus_idx   = q.idx;
    assign bus_wdata = q.sh;
    assign status    = q.stat;
    assign sda_oe    = (q.st == E_ACK_LO) || (q.st == E_ACK_HI) ||
                       (((q.st == E_TX_LO) || (q.st == E_TX_HI)) && !q.sh[BYTE_W-1]);
endmodule

// File: rtl/i2c10_mbox_slave.sv
module i2c10_mbox_slave
    import i2c10_pkg::*;
#(
    parameter int TMO_W     = 16,
    parameter int IDX_W     = 4,
    parameter int SYNC_STGS = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    scl_i,
    input  logic                    sda_i,
    output logic                    sda_oe_o,
    input  logic [BYTE_W-1:0]       cfg_id_hi,
    input  logic [BYTE_W-IDX_W-1:0] cfg_id_lo,
    input  logic [TMO_W-1:0]        cfg_clk_tmo,
    input  logic [TMO_W-1:0]        cfg_start_tmo,
    input  logic                    host_we,
    input  logic [IDX_W-1:0]        host_addr,
    input  logic [BYTE_W-1:0]       host_wdata,
    output logic [BYTE_W-1:0]       host_rdata,
    input  logic                    ready_clr,
    output logic [BYTE_W-1:0]       status_o
);
    logic sda_s, scl_rise, scl_fall, start_det, stop_det;
    logic bus_we;
    logic [IDX_W-1:0]  bus_idx;
    logic [BYTE_W-1:0] bus_wdata, bus_rdata;

    i2c10_sync #(.STAGES(SYNC_STGS)) u_sync (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
        .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_det(start_det), .stop_det(stop_det)
    );

    i2c10_engine #(.TMO_W(TMO_W), .IDX_W(IDX_W)) u_eng (
        .clk(clk), .rst_n(rst_n), .sda_s(sda_s),
        .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_det(start_det), .stop_det(stop_det),
        .cfg_id_hi(cfg_id_hi), .cfg_id_lo(cfg_id_lo),
        .cfg_clk_tmo(cfg_clk_tmo), .cfg_start_tmo(cfg_start_tmo),
        .ready_clr(ready_clr), .bus_rdata(bus_rdata),
        .bus_we(bus_we), .bus_idx(bus_idx), .bus_wdata(bus_wdata),
        .sda_oe(sda_oe_o), .status(status_o)
    );

    i2c10_mailbox #(.IDX_W(IDX_W)) u_mbox (
        .clk(clk), .rst_n(rst_n),
        .host_we(host_we), .host_addr(host_addr),
        .host_wdata(host_wdata), .host_rdata(host_rdata),
        .bus_we(bus_we), .bus_idx(bus_idx),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
    );
endmodule

// File: rtl/i2c10_mbox_slave_chk.sv
module i2c10_mbox_slave_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       scl_i,
    input logic       start_det,
    input logic       sda_oe_o,
    input logic       ready_clr,
    input logic [7:0] status_o
);
    // R5
    oe_rise_scl_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_oe_o) |-> !scl_i);

    // R8
    ovf_needs_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(status_o[1]) |-> $past(status_o[0]));

    // R8
    ready_fall_by_host_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(status_o[0]) |-> $past(ready_clr));

    // R11
    rstart_flag_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(status_o[4]) |-> $past(start_det));

    // R12
    err_has_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        status_o[7] |-> (status_o[3] || status_o[5]));
endmodule

bind i2c10_mbox_slave i2c10_mbox_slave_chk u_chk (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .start_det(start_det),
    .sda_oe_o(sda_oe_o), .ready_clr(ready_clr), .status_o(status_o)
);

// File: tb/i2c10_mbox_slave_tb.sv
module i2c10_mbox_slave_tb;
    localparam int Q = 20;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_m = 1'b1, sda_m = 1'b1;
    logic sda_oe_o, sda_line;
    logic host_we = 1'b0, ready_clr = 1'b0;
    logic [3:0] host_addr = '0;
    logic [7:0] host_wdata = '0, host_rdata, status_o;
    int n_chk = 0, n_fail = 0;

    always #2 clk = ~clk;
    assign sda_line = sda_m & ~sda_oe_o;

    i2c10_mbox_slave u_dut (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
        .sda_oe_o(sda_oe_o), .cfg_id_hi(8'hF4), .cfg_id_lo(4'hB),
        .cfg_clk_tmo(16'd100), .cfg_start_tmo(16'd300),
        .host_we(host_we), .host_addr(host_addr), .host_wdata(host_wdata),
        .host_rdata(host_rdata), .ready_clr(ready_clr), .status_o(status_o)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wq(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    task automatic peek(input logic [3:0] idx, output logic [7:0] v);
        host_addr = idx;
        @(negedge clk);
        v = host_rdata;
    endtask

    task automatic clr_ready();
        ready_clr = 1'b1;
        @(negedge clk);
        ready_clr = 1'b0;
        @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; scl_m = 1'b1; wq(Q);
        sda_m = 1'b0; wq(Q);
        scl_m = 1'b0; wq(Q);
    endtask

    task automatic bus_rstart();
        sda_m = 1'b1; wq(Q);
        scl_m = 1'b1; wq(Q);
        sda_m = 1'b0; wq(Q);
        scl_m = 1'b0; wq(Q);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; wq(Q);
        scl_m = 1'b1; wq(Q);
        sda_m = 1'b1; wq(Q);
    endtask

    task automatic put_bit(input logic b);
        sda_m = b; wq(Q);
        scl_m = 1'b1; wq(Q);
        scl_m = 1'b0; wq(Q);
    endtask

    task automatic get_bit(output logic b);
        sda_m = 1'b1; wq(Q);
        scl_m = 1'b1; wq(Q/2);
        b = sda_line; wq(Q/2);
        scl_m = 1'b0; wq(Q);
    endtask

    task automatic put_byte(input logic [7:0] v, output logic ack);
        logic b;
        for (int i = 7; i >= 0; i--) put_bit(v[i]);
        get_bit(b);
        ack = ~b;
    endtask

    task automatic get_byte(output logic [7:0] v);
        for (int i = 7; i >= 0; i--) get_bit(v[i]);
    endtask

    task automatic t_reset();
        logic [7:0] v;
        chk("R1 status", status_o, 8'h00);
        chk("R1 sda enable", {7'b0, sda_oe_o}, 8'h00);
        peek(4'h0, v); chk("R1 entry0", v, 8'h00);
        peek(4'hF, v); chk("R1 entry15", v, 8'h00);
    endtask

    task automatic t_host();
        logic [7:0] v;
        host_addr = 4'h2; host_wdata = 8'h5A; host_we = 1'b1;
        @(negedge clk);
        host_we = 1'b0;
        peek(4'h2, v); chk("R2 host write", v, 8'h5A);
        peek(4'h3, v); chk("R2 neighbour", v, 8'h00);
    endtask

    task automatic t_write();
        logic a1, a2, a3;
        logic [7:0] v;
        bus_start();
        put_byte(8'hF4, a1);
        put_byte(8'hB5, a2);
        put_byte(8'hA5, a3);
        bus_stop();
        chk("R3 ack first", {7'b0, a1}, 8'h01);
        chk("R4 ack second", {7'b0, a2}, 8'h01);
        chk("R5 ack data", {7'b0, a3}, 8'h01);
        peek(4'h5, v); chk("R6 stored byte", v, 8'hA5);
        chk("R6 ready", status_o, 8'h01);
    endtask

    task automatic t_overflow();
        logic a1, a2, a3;
        bus_start();
        put_byte(8'hF4, a1);
        put_byte(8'hB6, a2);
        put_byte(8'h3C, a3);
        bus_stop();
        chk("R8 overflow", status_o, 8'h03);
        clr_ready();
        chk("R8 ready cleared", status_o, 8'h02);
    endtask

    task automatic t_read();
        logic a1, a2, b;
        logic [7:0] v;
        bus_start();
        put_byte(8'hF5, a1);
        put_byte(8'hB5, a2);
        get_byte(v);
        put_bit(1'b1);
        bus_stop();
        chk("R7 acks", {6'b0, a1, a2}, 8'h03);
        chk("R7 read data", v, 8'hA5);
        chk("R13 R7 status after read", status_o, 8'h40);
        b = sda_oe_o;
        chk("R5 released", {7'b0, b}, 8'h00);
    endtask

    task automatic t_mismatch();
        logic a1, a2;
        bus_start();
        put_byte(8'hF6, a1);
        put_byte(8'hB5, a2);
        bus_stop();
        chk("R3 no ack on wrong id", {6'b0, a1, a2}, 8'h00);
        chk("R13 status cleared", status_o, 8'h00);
        bus_start();
        put_byte(8'hF4, a1);
        put_byte(8'hC5, a2);
        bus_stop();
        chk("R4 wrong nibble", {6'b0, a1, a2}, 8'h02);
    endtask

    task automatic t_wake();
        logic a0, a1, a2, a3;
        logic [7:0] v;
        bus_start();
        put_byte(8'h01, a0);
        bus_rstart();
        put_byte(8'hF4, a1);
        put_byte(8'hB7, a2);
        put_byte(8'h81, a3);
        bus_stop();
        chk("R9 start byte not acked", {7'b0, a0}, 8'h00);
        chk("R9 acks after start", {5'b0, a1, a2, a3}, 8'h07);
        peek(4'h7, v); chk("R9 data stored", v, 8'h81);
        chk("R9 no flags", status_o, 8'h01);
        clr_ready();
    endtask

    task automatic t_wake_tmo();
        logic a0, a1;
        bus_start();
        put_byte(8'h01, a0);
        wq(400);
        put_byte(8'hF4, a1);
        bus_stop();
        chk("R9 idle after wait", {6'b0, a0, a1}, 8'h00);
        chk("R9 no flags on expiry", status_o, 8'h00);
    endtask

    task automatic t_stop();
        logic a1, a2;
        logic [7:0] v;
        bus_start();
        put_byte(8'hF4, a1);
        put_byte(8'hB5, a2);
        put_bit(1'b1); put_bit(1'b0); put_bit(1'b1);
        bus_stop();
        chk("R10 stop flags", status_o, 8'h88);
        peek(4'h5, v); chk("R10 entry kept", v, 8'hA5);
    endtask

    task automatic t_rstart();
        logic a1, a2, a3, a4, a5;
        logic [7:0] v;
        bus_start();
        put_byte(8'hF4, a1);
        put_byte(8'hB9, a2);
        put_bit(1'b1); put_bit(1'b1);
        bus_rstart();
        put_byte(8'hF4, a3);
        put_byte(8'hB9, a4);
        put_byte(8'h66, a5);
        bus_stop();
        chk("R11 acks after restart", {5'b0, a3, a4, a5}, 8'h07);
        chk("R11 flag", status_o, 8'h11);
        peek(4'h9, v); chk("R11 data", v, 8'h66);
        clr_ready();
    endtask

    task automatic t_timeout();
        bus_start();
        put_bit(1'b1); put_bit(1'b1); put_bit(1'b1);
        wq(300);
        chk("R12 timeout flags", status_o, 8'hA0);
        chk("R12 released", {7'b0, sda_oe_o}, 8'h00);
        bus_stop();
        chk("R12 idle stop ignored", status_o, 8'hA0);
    endtask

    task automatic t_collide();
        logic a1, a2, b;
        logic [7:0] v;
        bus_start();
        put_byte(8'hF4, a1);
        put_byte(8'hBC, a2);
        host_addr = 4'hC; host_wdata = 8'h3C;
        for (int i = 7; i >= 1; i--) put_bit(i[0]);
        sda_m = 1'b0; wq(Q);
        scl_m = 1'b1; wq(Q);
        scl_m = 1'b0;
        @(negedge clk); host_we = 1'b1;
        @(negedge clk);
        @(negedge clk); host_we = 1'b0;
        wq(Q - 3);
        get_bit(b);
        bus_stop();
        chk("R14 acks", {5'b0, a1, a2, ~b}, 8'h07);
        peek(4'hC, v); chk("R14 host wins", v, 8'h3C);
        clr_ready();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        summary();
    end

    initial begin
        wq(3);
        rst_n = 1'b1;
        wq(3);
        t_reset();
        t_host();
        t_write();
        t_overflow();
        t_read();
        t_mismatch();
        t_wake();
        t_wake_tmo();
        t_stop();
        t_rstart();
        t_timeout();
        t_collide();
        summary();
    end
endmodule